// File: doc/BRIEF.md
# Inter-VM Doorbell and Interrupt Register Block

This block gives a guest processor a small word-addressed register window for a device through which virtual machines signal one another. Software sees four registers: an interrupt enable mask, an interrupt status word, a read-only word holding the device's own peer number, and a write-only doorbell. A level interrupt is raised while any enabled status bit is set. Reading the status word returns it and empties it, so one read both fetches and acknowledges the pending causes.

A doorbell write names a target peer in its upper half and a vector in its low byte. The block checks both fields against a peer table: the highest peer number in use, plus a registered vector count for each of up to 16 peers. An accepted doorbell leaves the block as a one-cycle notify pulse carrying the two fields. A rejected one leaves no trace. The peer table is loaded through a separate configuration port. A side input lets events arriving from other peers overwrite the status word with an 8-bit cause code.

Only full 32-bit accesses act. Narrower writes are dropped and narrower reads return zero. Every bus access finishes in the cycle it is presented, and read data is returned combinationally in that same cycle.

Top module: `vmdb_regs`

## Requirements
- R1: After reset, the mask, the status word, the highest peer number and every per-peer vector count are zero, and `irq` and `ntf_valid` are low.
- R2: The decoded word offsets are fixed: mask at 0x00, status at 0x04, own position at 0x08 and doorbell at 0x0C, inside a 0x100-byte window. A word read of the doorbell or of any other offset returns zero.
- R3: `irq` is high exactly when the bitwise AND of the status word and the mask is nonzero. It takes its new value in the cycle after the write that changed either register.
- R4: A word read at 0x04 returns the current status. The status is zero from the next cycle on, unless an event arrives in that same cycle.
- R5: A word write to the mask or the status register replaces all 32 bits of that register.
- R6: A word write to the doorbell takes the peer from bits 31:16 and the vector from bits 7:0. Bits 15:8 are ignored. If the write is accepted, `ntf_valid` is high for exactly the next cycle, with `ntf_peer` and `ntf_vector` carrying those fields.
- R7: A doorbell write is dropped and gives no pulse in three cases: the peer is greater than the highest peer number, the peer is 16 or more, or the vector is not below that peer's vector count.
- R8: A word read at 0x08 returns the own peer number, zero-extended, while `shm_mapped` is high. It returns 0xFFFFFFFF while `shm_mapped` is low.
- R9: `bus_size` encodes 0 = byte, 1 = halfword, 2 = word, with 3 reserved. Any access that is not a word changes no register, gives no notify pulse, and reads as zero.
- R10: Writes decode address bits 7:2 only, so a word write at 0x07 reaches the status register. A read with nonzero address bits 1:0 returns zero and does not clear the status.
- R11: A cycle with `evt_valid` high loads the status word with `evt_data` zero-extended. This takes priority over a same-cycle status write or status read-clear.
- R12: `cfg_max_we` loads the highest peer number. `cfg_cnt_we` loads the vector count of peer `cfg_cnt_idx`. Both take effect for doorbells from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address inside the window |
| bus_size | input | 2 | Access size code (R9) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| evt_valid | input | 1 | Incoming peer event |
| evt_data | input | 8 | Cause code loaded into status |
| my_peer_id | input | 16 | Own peer number |
| shm_mapped | input | 1 | Shared region is mapped |
| cfg_max_we | input | 1 | Load highest peer number |
| cfg_max_peer | input | 16 | Highest peer number value |
| cfg_cnt_we | input | 1 | Load one peer's vector count |
| cfg_cnt_idx | input | 4 | Peer whose count is loaded |
| cfg_cnt_val | input | 9 | Vector count, 0 to 256 |
| irq | output | 1 | Level interrupt |
| ntf_valid | output | 1 | One-cycle accepted-doorbell pulse |
| ntf_peer | output | 16 | Target peer of the pulse |
| ntf_vector | output | 8 | Vector of the pulse |

## Verification
Read data is combinational, so each read is sampled in the cycle it is presented, before the clock edge that clears the status. `irq`, `ntf_valid` and register contents change one edge after the access, configuration load or event that causes them. The bench therefore drives each stimulus on a falling edge and checks its result on the following falling edge. The doorbell check sweeps every peer from 0 to 17 against every vector from 0 to 6, with per-peer counts set by a formula. The interrupt check walks a single mask bit across all 32 positions, with expected values from a bench-side model of the mask and status words.

// File: rtl/vmdb_pkg.sv
// Shared constants for the inter-VM doorbell register block.
// Assumes a 32-bit data bus and a 256-byte window decoded by word index.
package vmdb_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int WIDX_W = ADDR_W - 2;

    // Word indices (byte offset >> 2)
    localparam logic [WIDX_W-1:0] WIDX_MASK = 6'd0;
    localparam logic [WIDX_W-1:0] WIDX_STAT = 6'd1;
    localparam logic [WIDX_W-1:0] WIDX_POS  = 6'd2;
    localparam logic [WIDX_W-1:0] WIDX_BELL = 6'd3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } bus_size_e;
endpackage

// File: rtl/vmdb_peer_table.sv
// Peer table: highest peer number plus one vector count per peer slot.
// Answers whether a (peer, vector) pair may be rung. Cleared by reset.
// Assumes NUM_PEERS is a power of two and fits below 2**PID_W.
module vmdb_peer_table #(
    parameter int NUM_PEERS = 16,
    parameter int PID_W     = 16,
    parameter int VEC_W     = 8,
    localparam int IDX_W    = $clog2(NUM_PEERS),
    localparam int CNT_W    = VEC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_max_we,
    input  logic [PID_W-1:0] cfg_max_peer,
    input  logic             cfg_cnt_we,
    input  logic [IDX_W-1:0] cfg_cnt_idx,
    input  logic [CNT_W-1:0] cfg_cnt_val,
    input  logic [PID_W-1:0] lk_peer,
    input  logic [VEC_W-1:0] lk_vec,
    output logic             lk_ok
);
    logic [PID_W-1:0] max_q;
    logic [CNT_W-1:0] cnt_q [NUM_PEERS];
    logic             in_range;
    logic [CNT_W-1:0] sel_cnt;

    // Hold the highest peer number in use.
    always_ff @(posedge clk) begin
        if (!rst_n)          max_q <= '0;
        else if (cfg_max_we) max_q <= cfg_max_peer;
    end

    // One vector-count register per peer slot.
    for (genvar g = 0; g < NUM_PEERS; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q[g] <= '0;
            else if (cfg_cnt_we && cfg_cnt_idx == IDX_W'(g))
                cnt_q[g] <= cfg_cnt_val;
        end
    end

    // Range-check the peer, then compare the vector with its count.
    always_comb begin
        in_range = (lk_peer <= max_q) && (lk_peer < PID_W'(NUM_PEERS));
        sel_cnt  = cnt_q[lk_peer[IDX_W-1:0]];
        lk_ok    = in_range && (CNT_W'(lk_vec) < sel_cnt);
    end

    // R12
    max_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_max_we |=> max_q == $past(cfg_max_peer));
endmodule

// File: rtl/vmdb_irq_ctrl.sv
// Mask and status registers with the level interrupt.
// Status priority: peer event, then bus write, then read-clear.
// Assumes the write and read-clear strobes are never high together.
module vmdb_irq_ctrl #(
    parameter int DATA_W = 32,
    parameter int EVT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic              stat_we,
    input  logic              stat_rd_clr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              evt_valid,
    input  logic [EVT_W-1:0]  evt_data,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] stat_q,
    output logic              irq
);
    // Mask register, replaced whole on write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata;
    end

    // Status register: event load, bus write or clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n)           stat_q <= '0;
        else if (evt_valid)   stat_q <= DATA_W'(evt_data);
        else if (stat_we)     stat_q <= wdata;
        else if (stat_rd_clr) stat_q <= '0;
    end

    // Level interrupt from enabled pending bits.
    always_comb irq = |(stat_q & mask_q);

    // R4
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_clr && !evt_valid && !stat_we) |=> stat_q == '0);
    // R11
    evt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> stat_q == DATA_W'($past(evt_data)));
    // R5
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> mask_q == $past(wdata));
endmodule

// File: rtl/vmdb_bell.sv
// Doorbell field split and one-cycle notify pulse.
// Assumes lk_ok is the peer-table verdict for the fields driven out on lk_*.
module vmdb_bell #(
    parameter int DATA_W = 32,
    parameter int PID_W  = 16,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bell_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lk_ok,
    output logic [PID_W-1:0]  lk_peer,
    output logic [VEC_W-1:0]  lk_vec,
    output logic              ntf_valid,
    output logic [PID_W-1:0]  ntf_peer,
    output logic [VEC_W-1:0]  ntf_vector
);
    // Split the doorbell word into peer and vector fields.
    always_comb begin
        lk_peer = wdata[DATA_W-1 -: PID_W];
        lk_vec  = wdata[VEC_W-1:0];
    end

    // Register an accepted doorbell as a single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ntf_valid  <= 1'b0;
            ntf_peer   <= '0;
            ntf_vector <= '0;
        end else begin
            ntf_valid <= bell_we && lk_ok;
            if (bell_we && lk_ok) begin
                ntf_peer   <= lk_peer;
                ntf_vector <= lk_vec;
            end
        end
    end

    // R6
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |-> $past(bell_we));
endmodule

// File: rtl/vmdb_regs.sv
// Inter-VM doorbell register block: bus decode, read mux and the wiring
// of the peer table, the interrupt registers and the doorbell path.
// Assumes a single-cycle bus with read data taken in the access cycle.
module vmdb_regs
    import vmdb_pkg::*;
#(
    parameter int NUM_PEERS = 16,
    parameter int PID_W     = 16,
    parameter int VEC_W     = 8,
    parameter int EVT_W     = 8,
    localparam int IDX_W    = $clog2(NUM_PEERS),
    localparam int CNT_W    = VEC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_valid,
    input  logic [EVT_W-1:0]  evt_data,
    input  logic [PID_W-1:0]  my_peer_id,
    input  logic              shm_mapped,
    input  logic              cfg_max_we,
    input  logic [PID_W-1:0]  cfg_max_peer,
    input  logic              cfg_cnt_we,
    input  logic [IDX_W-1:0]  cfg_cnt_idx,
    input  logic [CNT_W-1:0]  cfg_cnt_val,
    output logic              irq,
    output logic              ntf_valid,
    output logic [PID_W-1:0]  ntf_peer,
    output logic [VEC_W-1:0]  ntf_vector
);
    logic              word_wr, word_rd, rd_aligned;
    logic [WIDX_W-1:0] widx;
    logic              mask_we, stat_we, bell_we, stat_rd_clr;
    logic [DATA_W-1:0] mask_q, stat_q;
    logic [PID_W-1:0]  lk_peer;
    logic [VEC_W-1:0]  lk_vec;
    logic              lk_ok;

    // Decode word-sized accesses and per-register strobes.
    always_comb begin
        word_wr     = bus_valid && bus_write  && (bus_size == SZ_WORD);
        word_rd     = bus_valid && !bus_write && (bus_size == SZ_WORD);
        widx        = bus_addr[ADDR_W-1:2];
        rd_aligned  = word_rd && (bus_addr[1:0] == 2'b00);
        mask_we     = word_wr && (widx == WIDX_MASK);
        stat_we     = word_wr && (widx == WIDX_STAT);
        bell_we     = word_wr && (widx == WIDX_BELL);
        stat_rd_clr = rd_aligned && (widx == WIDX_STAT);
    end

    // Read multiplexer; anything undefined reads as zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_aligned) begin
            unique case (widx)
                WIDX_MASK: bus_rdata = mask_q;
                WIDX_STAT: bus_rdata = stat_q;
                WIDX_POS:  bus_rdata = shm_mapped ? DATA_W'(my_peer_id) : '1;
                default:   bus_rdata = '0;
            endcase
        end
    end

    vmdb_irq_ctrl #(.DATA_W(DATA_W), .EVT_W(EVT_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .mask_we(mask_we), .stat_we(stat_we), .stat_rd_clr(stat_rd_clr),
        .wdata(bus_wdata), .evt_valid(evt_valid), .evt_data(evt_data),
        .mask_q(mask_q), .stat_q(stat_q), .irq(irq)
    );

    vmdb_peer_table #(.NUM_PEERS(NUM_PEERS), .PID_W(PID_W), .VEC_W(VEC_W)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .cfg_max_we(cfg_max_we), .cfg_max_peer(cfg_max_peer),
        .cfg_cnt_we(cfg_cnt_we), .cfg_cnt_idx(cfg_cnt_idx), .cfg_cnt_val(cfg_cnt_val),
        .lk_peer(lk_peer), .lk_vec(lk_vec), .lk_ok(lk_ok)
    );

    vmdb_bell #(.DATA_W(DATA_W), .PID_W(PID_W), .VEC_W(VEC_W)) u_bell (
        .clk(clk), .rst_n(rst_n),
        .bell_we(bell_we), .wdata(bus_wdata), .lk_ok(lk_ok),
        .lk_peer(lk_peer), .lk_vec(lk_vec),
        .ntf_valid(ntf_valid), .ntf_peer(ntf_peer), .ntf_vector(ntf_vector)
    );

    // R9
    narrow_no_bell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_size != SZ_WORD) |=> !ntf_valid);
    // R9
    narrow_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_size != SZ_WORD) |-> bus_rdata == '0);
endmodule

// File: tb/vmdb_regs_tb.sv
`timescale 1ns/1ps
module vmdb_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid, bus_write;
    logic [7:0]  bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata, bus_rdata;
    logic        evt_valid;
    logic [7:0]  evt_data;
    logic [15:0] my_peer_id;
    logic        shm_mapped;
    logic        cfg_max_we, cfg_cnt_we;
    logic [15:0] cfg_max_peer;
    logic [3:0]  cfg_cnt_idx;
    logic [8:0]  cfg_cnt_val;
    logic        irq, ntf_valid;
    logic [15:0] ntf_peer;
    logic [7:0]  ntf_vector;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    vmdb_regs u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_valid(evt_valid), .evt_data(evt_data),
        .my_peer_id(my_peer_id), .shm_mapped(shm_mapped),
        .cfg_max_we(cfg_max_we), .cfg_max_peer(cfg_max_peer),
        .cfg_cnt_we(cfg_cnt_we), .cfg_cnt_idx(cfg_cnt_idx), .cfg_cnt_val(cfg_cnt_val),
        .irq(irq), .ntf_valid(ntf_valid), .ntf_peer(ntf_peer), .ntf_vector(ntf_vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a; bus_size = sz;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic set_cnt(input int p, input int c);
        @(negedge clk);
        cfg_cnt_we = 1; cfg_cnt_idx = 4'(p); cfg_cnt_val = 9'(c);
        @(negedge clk);
        cfg_cnt_we = 0;
    endtask

    task automatic set_max(input int m);
        @(negedge clk);
        cfg_max_we = 1; cfg_max_peer = 16'(m);
        @(negedge clk);
        cfg_max_we = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic int cnt_of(input int p);
        return (p * 3) % 7;
    endfunction

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd, m, s, wd;
        bit exp_ok;
        int max_p;
        rst_n = 0; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_size = 2;
        bus_wdata = 0; evt_valid = 0; evt_data = 0; my_peer_id = 16'h0042;
        shm_mapped = 1; cfg_max_we = 0; cfg_cnt_we = 0; cfg_max_peer = 0;
        cfg_cnt_idx = 0; cfg_cnt_val = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 ntf_valid", 32'(ntf_valid), 0);
        bus_rd(8'h00, 2'd2, rd); check("R1 mask", rd, 0);
        bus_rd(8'h04, 2'd2, rd); check("R1 status", rd, 0);
        // R1: table cleared, peer 0 vector 0 rejected
        bus_wr(8'h0C, 2'd2, 32'h0000_0000); check("R1 table empty", 32'(ntf_valid), 0);

        // R12 configure table
        max_p = 9;
        set_max(max_p);
        for (int p = 0; p < 16; p++) set_cnt(p, cnt_of(p));

        // R6 R7 doorbell sweep
        for (int p = 0; p < 18; p++) begin
            for (int v = 0; v < 7; v++) begin
                exp_ok = (p <= max_p) && (p < 16) && (v < cnt_of(p));
                bus_wr(8'h0C, 2'd2, {16'(p), 8'hA5, 8'(v)});
                check("R7 accept", 32'(ntf_valid), 32'(exp_ok));
                if (exp_ok) begin
                    check("R6 peer", 32'(ntf_peer), 32'(p));
                    check("R6 vector", 32'(ntf_vector), 32'(v));
                end
                @(negedge clk);
                check("R6 single cycle", 32'(ntf_valid), 0);
            end
        end

        // R3 R5 interrupt sweep with bench model
        m = 0; s = 0;
        for (int i = 0; i < 32; i++) begin
            m = 32'h1 << i;
            bus_wr(8'h00, 2'd2, m);
            check("R3 irq after mask", 32'(irq), 32'(|(m & s)));
            s = (i % 2 == 1) ? (32'h1 << i) : ~(32'h1 << i);
            bus_wr(8'h04, 2'd2, s);
            check("R3 irq after status", 32'(irq), 32'(|(m & s)));
        end
        bus_rd(8'h00, 2'd2, rd); check("R5 mask readback", rd, m);

        // R4 R5 read clears status
        bus_wr(8'h00, 2'd2, 32'hFFFF_FFFF);
        bus_wr(8'h04, 2'd2, 32'h5A5A_1234);
        check("R3 irq pending", 32'(irq), 1);
        bus_rd(8'h04, 2'd2, rd); check("R4 read value", rd, 32'h5A5A_1234);
        check("R4 irq cleared", 32'(irq), 0);
        bus_rd(8'h04, 2'd2, rd); check("R4 status zero", rd, 0);

        // R8 R2 position and undefined offsets
        bus_rd(8'h08, 2'd2, rd); check("R8 mapped id", rd, 32'h0000_0042);
        shm_mapped = 0;
        bus_rd(8'h08, 2'd2, rd); check("R8 unmapped", rd, 32'hFFFF_FFFF);
        shm_mapped = 1;
        bus_rd(8'h0C, 2'd2, rd); check("R2 doorbell read", rd, 0);
        bus_rd(8'h10, 2'd2, rd); check("R2 undefined", rd, 0);
        bus_rd(8'hFC, 2'd2, rd); check("R2 top word", rd, 0);

        // R10 masked write address, unaligned read
        bus_wr(8'h07, 2'd2, 32'h0000_00F0);
        bus_rd(8'h05, 2'd2, rd); check("R10 unaligned read", rd, 0);
        bus_rd(8'h04, 2'd2, rd); check("R10 masked write hit status", rd, 32'h0000_00F0);

        // R9 narrow accesses
        bus_wr(8'h00, 2'd0, 32'h0000_0000);
        bus_wr(8'h00, 2'd1, 32'h0000_0000);
        bus_wr(8'h04, 2'd3, 32'h0000_0001);
        bus_rd(8'h00, 2'd2, rd); check("R9 narrow write ignored", rd, 32'hFFFF_FFFF);
        bus_rd(8'h00, 2'd1, rd); check("R9 half read", rd, 0);
        bus_rd(8'h00, 2'd0, rd); check("R9 byte read", rd, 0);
        bus_rd(8'h04, 2'd2, rd); check("R9 status untouched", rd, 0);
        bus_wr(8'h0C, 2'd0, {16'd2, 8'd0, 8'd0});
        check("R9 byte doorbell", 32'(ntf_valid), 0);

        // R11 event load and priority
        @(negedge clk); evt_valid = 1; evt_data = 8'h81;
        @(negedge clk); evt_valid = 0;
        check("R11 irq on event", 32'(irq), 1);
        bus_rd(8'h04, 2'd2, rd); check("R11 event value", rd, 32'h0000_0081);
        bus_wr(8'h04, 2'd2, 32'h0000_0003);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = 8'h04; bus_size = 2'd2;
        evt_valid = 1; evt_data = 8'h44;
        #1 rd = bus_rdata;
        @(negedge clk); bus_valid = 0; evt_valid = 0;
        check("R11 read during event", rd, 32'h0000_0003);
        bus_rd(8'h04, 2'd2, rd); check("R11 event beats clear", rd, 32'h0000_0044);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 8'h04; bus_size = 2'd2;
        bus_wdata = 32'h1234_0000; evt_valid = 1; evt_data = 8'h12;
        @(negedge clk); bus_valid = 0; bus_write = 0; evt_valid = 0;
        bus_rd(8'h04, 2'd2, rd); check("R11 event beats write", rd, 32'h0000_0012);

        // R12 table reload
        set_max(2);
        bus_wr(8'h0C, 2'd2, {16'd3, 8'd0, 8'd0}); check("R12 new max drops", 32'(ntf_valid), 0);
        bus_wr(8'h0C, 2'd2, {16'd2, 8'd0, 8'd5}); check("R12 new max accepts", 32'(ntf_valid), 1);
        set_cnt(2, 0);
        bus_wr(8'h0C, 2'd2, {16'd2, 8'd0, 8'd0}); check("R12 count zero drops", 32'(ntf_valid), 0);

        wd = 0;
        done = 1;
        finish_run();
    end
endmodule